// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block watches a stream of converter results and raises a sticky alarm when a result leaves a programmed window. Each result arrives as a 12-bit raw value with a 5-bit channel number and a one-cycle valid strobe. The comparison uses the raw value, before any alignment step, against a 12-bit lower bound and a 12-bit upper bound.

The monitor can guard every channel or only one chosen channel. Software sets it up through a small register port: a configuration word, two bound registers and a status word. The alarm bit in the status word stays set until software writes a 1 to it. An interrupt output follows the alarm while the interrupt enable is set.

Top module: `win_guard`

## Requirements
- R1: When monitoring applies to a valid result and the value is strictly greater than the upper bound, `alarmFlag` is 1 from the clock edge that samples that result onward.
- R2: When monitoring applies to a valid result and the value is strictly less than the lower bound, `alarmFlag` is set in the same way.
- R3: A value equal to the lower bound or equal to the upper bound is inside the window and does not set the flag.
- R4: After reset the monitor is off (config bit 0 is 0). While it is off, no result sets the flag.
- R5: With the enable bit (config bit 0) at 1 and the single-channel bit (config bit 1) at 0, results on any channel number are checked.
- R6: With the single-channel bit at 1, only results whose channel number equals config bits [8:4] are checked. Results on other channels never set the flag.
- R7: The flag is sticky. Writing address 3 with bit 0 at 1 clears it. Writing address 3 with bit 0 at 0 has no effect. If a set and a clear fall on the same edge, the flag ends up set.
- R8: `alarmIrq` is 1 exactly while the flag is 1 and the interrupt enable (config bit 2) is 1.
- R9: The lower bound (address 1, bits [11:0]) and the upper bound (address 2, bits [11:0]) are written separately. Writing one leaves the other unchanged. Both can be read back at the same addresses.
- R10: Reset values are: config 0, lower bound 0x000, upper bound 0xFFF, flag 0. Unused read bits are 0. Address 3 reads the flag in bit 0.
- R11: A cycle with `resValid` low never sets the flag, whatever the value and channel inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Result strobe |
| resVal | input | 12 | Raw conversion result |
| resChan | input | 5 | Channel number of the result |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 config, 1 lower bound, 2 upper bound, 3 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| alarmFlag | output | 1 | Sticky out-of-window flag |
| alarmIrq | output | 1 | Interrupt request |

## Verification
The comparison is tried with values just inside, on and just outside each bound, which separates a strict compare from an inclusive one. Random values spread over the full 12-bit range, with random channels and random clears, are checked against a reference model. Channel filtering is tried by feeding the selected channel and its neighbours in single-channel mode and then in all-channel mode, which shows that the filter is applied only when it is requested. Cycles with the strobe low but an out-of-window value show that results are gated by the strobe. Clears that land on the same cycle as a violation show which of the two wins.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int DATA_W = 12;
  localparam int CHAN_W = 5;
  localparam int ADDR_W = 2;
  localparam int REG_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_SGL_BIT  = 1;
  localparam int CFG_IRQ_BIT  = 2;
  localparam int CFG_CHAN_LSB = 4;

  typedef struct packed {
    logic              enable;
    logic              singleSel;
    logic [CHAN_W-1:0] chanSel;
    logic [DATA_W-1:0] lowThr;
    logic [DATA_W-1:0] highThr;
    logic              clearReq;
  } wg_ctl_t;
endpackage

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import wg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              flagIn,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqEn,
  output wg_ctl_t           ctl
);
  localparam logic [DATA_W-1:0] HIGH_RST = {DATA_W{1'b1}};
  localparam int CHAN_MSB = CFG_CHAN_LSB + CHAN_W - 1;

  logic              cfgEnable;
  logic              cfgSingle;
  logic              cfgIrq;
  logic [CHAN_W-1:0] cfgChan;
  logic [DATA_W-1:0] lowThr;
  logic [DATA_W-1:0] highThr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgEnable <= 1'b0;
      cfgSingle <= 1'b0;
      cfgIrq    <= 1'b0;
      cfgChan   <= '0;
      lowThr    <= '0;
      highThr   <= HIGH_RST;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CFG: begin
          cfgEnable <= regWrData[CFG_EN_BIT];
          cfgSingle <= regWrData[CFG_SGL_BIT];
          cfgIrq    <= regWrData[CFG_IRQ_BIT];
          cfgChan   <= regWrData[CHAN_MSB:CFG_CHAN_LSB];
        end
        ADDR_LOW:  lowThr  <= regWrData[DATA_W-1:0];
        ADDR_HIGH: highThr <= regWrData[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CFG: begin
        regRdData[CFG_EN_BIT]            = cfgEnable;
        regRdData[CFG_SGL_BIT]           = cfgSingle;
        regRdData[CFG_IRQ_BIT]           = cfgIrq;
        regRdData[CHAN_MSB:CFG_CHAN_LSB] = cfgChan;
      end
      ADDR_LOW:  regRdData[DATA_W-1:0] = lowThr;
      ADDR_HIGH: regRdData[DATA_W-1:0] = highThr;
      default:   regRdData[0] = flagIn;
    endcase
  end

  always_comb begin
    ctl.enable    = cfgEnable;
    ctl.singleSel = cfgSingle;
    ctl.chanSel   = cfgChan;
    ctl.lowThr    = lowThr;
    ctl.highThr   = highThr;
    ctl.clearReq  = regWrEn && (regAddr == ADDR_STAT) && regWrData[0];
  end

  assign irqEn = cfgIrq;
endmodule

// File: rtl/wg_datapath.sv
module wg_datapath
  import wg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resVal,
  input  logic [CHAN_W-1:0] resChan,
  input  wg_ctl_t           ctl,
  output logic              flag
);
  logic chanOk;
  logic aboveHigh;
  logic belowLow;
  logic excursion;

  assign chanOk    = !ctl.singleSel || (resChan == ctl.chanSel);
  assign aboveHigh = resVal > ctl.highThr;
  assign belowLow  = resVal < ctl.lowThr;
  assign excursion = resValid && ctl.enable && chanOk && (aboveHigh || belowLow);

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (excursion)
      flag <= 1'b1;
    else if (ctl.clearReq)
      flag <= 1'b0;
  end
endmodule

// File: rtl/win_guard.sv
module win_guard
  import wg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resValid,
  input  logic [DATA_W-1:0] resVal,
  input  logic [CHAN_W-1:0] resChan,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  wg_ctl_t ctlBus;
  logic    irqEn;
  logic    flagQ;

  wg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .flagIn(flagQ), .regRdData(regRdData),
    .irqEn(irqEn), .ctl(ctlBus)
  );

  wg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .resValid(resValid), .resVal(resVal),
    .resChan(resChan), .ctl(ctlBus), .flag(flagQ)
  );

  assign alarmFlag = flagQ;
  assign alarmIrq  = flagQ && irqEn;
endmodule

// File: rtl/wg_checker.sv
module wg_checker
  import wg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              resValid,
  input logic [DATA_W-1:0] resVal,
  input logic [CHAN_W-1:0] resChan,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic              alarmFlag,
  input logic              alarmIrq,
  input wg_ctl_t           ctlBus,
  input logic              irqEn
);
  logic applies;
  logic outside;
  logic clrWrite;
  assign applies  = resValid && ctlBus.enable &&
                    (!ctlBus.singleSel || resChan == ctlBus.chanSel);
  assign outside  = (resVal > ctlBus.highThr) || (resVal < ctlBus.lowThr);
  assign clrWrite = regWrEn && regAddr == ADDR_STAT && regWrData[0];

  p_set_on_excursion_r1: assert property (@(posedge clk) disable iff (!rst_n)
    applies && outside |=> alarmFlag);
  p_inside_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !outside |=> !$rose(alarmFlag));
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlBus.enable |=> !$rose(alarmFlag));
  p_other_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctlBus.singleSel && resChan != ctlBus.chanSel |=> !$rose(alarmFlag));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarmFlag && !clrWrite |=> alarmFlag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clrWrite && !(applies && outside) |=> !alarmFlag);
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarmIrq |-> alarmFlag && irqEn);
  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |=> !$rose(alarmFlag));
endmodule

bind win_guard wg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .resValid(resValid), .resVal(resVal),
  .resChan(resChan), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .alarmFlag(alarmFlag), .alarmIrq(alarmIrq),
  .ctlBus(ctlBus), .irqEn(irqEn)
);

// File: tb/sim_win_guard.sv
module sim_win_guard;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        resValid = 0;
  logic [11:0] resVal = 0;
  logic [4:0]  resChan = 0;
  logic        regWrEn = 0;
  logic [1:0]  regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        alarmFlag, alarmIrq;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  logic        mEn = 0, mSgl = 0, mIrq = 0, mFlag = 0;
  logic [4:0]  mChan = 0;
  logic [11:0] mLow = 12'h000, mHigh = 12'hFFF;

  always #2 clk = ~clk;

  win_guard u0 (.*);

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic logic hitModel(logic v, logic [11:0] val, logic [4:0] ch);
    return v && mEn && (!mSgl || ch == mChan) && (val > mHigh || val < mLow);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock cycle with optional write and optional result
  task automatic cyc(logic we, logic [1:0] a, logic [31:0] d,
                     logic v, logic [11:0] val, logic [4:0] ch, string req);
    logic hit, clr;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d;
    resValid = v; resVal = val; resChan = ch;
    hit = hitModel(v, val, ch);
    clr = we && a == 2'd3 && d[0];
    @(posedge clk); #1;
    if (hit) mFlag = 1; else if (clr) mFlag = 0;
    if (we) begin
      case (a)
        2'd0: begin mEn = d[0]; mSgl = d[1]; mIrq = d[2]; mChan = d[8:4]; end
        2'd1: mLow = d[11:0];
        2'd2: mHigh = d[11:0];
        default: ;
      endcase
    end
    regWrEn = 0; resValid = 0;
    chk(req, {31'd0, alarmFlag}, {31'd0, mFlag});
    chk({req, "/R8"}, {31'd0, alarmIrq}, {31'd0, mFlag && mIrq});
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, regRdData, exp);
  endtask

  function automatic logic [31:0] cfgWord(logic en, logic sg, logic iq, logic [4:0] ch);
    return {23'd0, ch, 1'b0, iq, sg, en};
  endfunction

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R10 reset values
    rd(2'd0, 32'h0, "R10 cfg");
    rd(2'd1, 32'h0, "R10 low");
    rd(2'd2, 32'hFFF, "R10 high");
    rd(2'd3, 32'h0, "R10 flag");
    // R4 disabled after reset
    cyc(0, 0, 0, 1, 12'hFFF, 5'd0, "R4 off");
    cyc(0, 0, 0, 1, 12'h000, 5'd3, "R4 off");
    // R9 independent bounds
    cyc(1, 2'd2, 32'hE00, 0, 0, 0, "R9 high wr");
    rd(2'd1, 32'h0, "R9 low kept");
    cyc(1, 2'd1, 32'hFFFF_F200, 0, 0, 0, "R9 low wr");
    rd(2'd2, 32'hE00, "R9 high kept");
    rd(2'd1, 32'h200, "R9 low read");
    cyc(1, 2'd0, cfgWord(1, 0, 1, 5'd0), 0, 0, 0, "R5 cfg");
    rd(2'd0, 32'h5, "R10 cfg read");
    // R3 boundaries
    cyc(0, 0, 0, 1, 12'hE00, 5'd1, "R3 equal high");
    cyc(0, 0, 0, 1, 12'h200, 5'd9, "R3 equal low");
    // R11 strobe low
    cyc(0, 0, 0, 0, 12'hFFF, 5'd2, "R11 no strobe");
    // R1 above
    cyc(0, 0, 0, 1, 12'hE01, 5'd17, "R1 above");
    rd(2'd3, 32'h1, "R10 flag read");
    cyc(0, 0, 0, 1, 12'h400, 5'd0, "R7 sticky");
    cyc(1, 2'd3, 32'h0, 0, 0, 0, "R7 write zero");
    cyc(1, 2'd3, 32'h1, 0, 0, 0, "R7 clear");
    // R2 below, then set wins over clear
    cyc(0, 0, 0, 1, 12'h1FF, 5'd30, "R2 below");
    cyc(1, 2'd3, 32'h1, 1, 12'hF00, 5'd4, "R7 set beats clear");
    cyc(1, 2'd3, 32'h1, 0, 0, 0, "R7 clear");
    // R6 single channel
    cyc(1, 2'd0, cfgWord(1, 1, 1, 5'd12), 0, 0, 0, "R6 cfg");
    cyc(0, 0, 0, 1, 12'hFFF, 5'd11, "R6 neighbour");
    cyc(0, 0, 0, 1, 12'h000, 5'd13, "R6 neighbour");
    cyc(0, 0, 0, 1, 12'hFFF, 5'd12, "R6 selected");
    cyc(1, 2'd3, 32'h1, 0, 0, 0, "R7 clear");
    // R5 all channels again
    cyc(1, 2'd0, cfgWord(1, 0, 0, 5'd12), 0, 0, 0, "R5 cfg");
    cyc(0, 0, 0, 1, 12'h000, 5'd31, "R5 any chan");
    cyc(1, 2'd3, 32'h1, 0, 0, 0, "R7 clear");
    // R4 disable
    cyc(1, 2'd0, cfgWord(0, 0, 1, 5'd0), 0, 0, 0, "R4 cfg off");
    cyc(0, 0, 0, 1, 12'hFFF, 5'd0, "R4 off quiet");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0)
        cyc(1, 2'd0, cfgWord($urandom_range(0, 3) != 0, $urandom_range(0, 1),
            $urandom_range(0, 1), 5'($urandom_range(0, 3))), 0, 0, 0, "R6 rnd cfg");
      else if (sel == 1)
        cyc(1, 2'd1, 32'($urandom_range(0, 12'h7FF)), 0, 0, 0, "R9 rnd low");
      else if (sel == 2)
        cyc(1, 2'd2, 32'($urandom_range(12'h800, 12'hFFF)), 0, 0, 0, "R9 rnd high");
      else if (sel < 6)
        cyc(1, 2'd3, 32'($urandom_range(0, 1)), $urandom_range(0, 1),
            12'($urandom), 5'($urandom_range(0, 3)), "R7 rnd clear");
      else
        cyc(0, 0, 0, $urandom_range(0, 3) != 0, 12'($urandom),
            5'($urandom_range(0, 3)), "R1 rnd result");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule